// File: doc/BRIEF.md
# Two-Level Vectoring Interrupt Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core should service next. It holds a pending flag, an enable bit and a priority bit for each of seventeen sources, plus one global enable. Peripherals pulse `src_evt` to post events. Software reads and writes all of this state through a byte-wide register port.

At each instruction boundary reported by the core, the controller arbitrates among the pending, enabled sources. It then raises a held request that carries the winner's index and its fixed vector address. The core answers with `vec_ack` when it takes the vector and with `ret_stb` when a handler returns. From these two strobes the block tracks which priority levels are in service, which lets a high-priority handler preempt a low-priority one.

Clearing an enable takes effect with a delay of one instruction. On the boundary that ends the clearing instruction, the core reports through `ib_short` whether the next instruction is single-cycle. If it is, the old enable still counts on that boundary.

Top module: `irq_vectorer`

## Requirements
- R1: Register map. Select 0..2 are the flag bytes, 3..5 the enable bytes and 6..8 the priority bytes (1 = high). Source i sits at byte i/8 of its group, bit i%8. Select 9 is the control byte, with the global enable in bit 7. Unused bits read 0. A read returns current values combinationally, and a flag read also shows events posted in the same cycle.
- R2: A source event sets its flag on the next clock whatever the enables are. A source whose enable is 0 never wins arbitration.
- R3: While the global enable is 0, no request is raised, whatever the individual enables are.
- R4: Arbitration happens only on a cycle with `ib_stb` high. A winner drives `irq_req` high in the following cycle. `irq_req`, `irq_idx` and `irq_hi` then hold until `vec_ack`, and `irq_vec` equals 0x0003 + 8 × `irq_idx`.
- R5: Writing 1 to a flag bit sets it, and the source is then requested exactly as after a hardware event. Writing 0 clears it.
- R6: On `vec_ack`, the flag of the acknowledged source clears if that source is in the auto-clear mask (default: sources 0 and 4). Every other flag stays set.
- R7: A boundary that coincides with `ret_stb` is not an arbitration point. A flag that is still set is requested at the next boundary.
- R8: After a write clears an enable bit or the global enable, the old value still counts at the next boundary if `ib_short` is 1 there. It does not count if `ib_short` is 0, and it never counts at later boundaries.
- R9: A high request may interrupt a low handler. Nothing is requested while a high handler is in service. A low request waits while a low handler is in service.
- R10: Among eligible sources, the high level wins over the low level. Within a level, the lowest index wins.
- R11: Synchronous reset clears all flags, enables, priorities, the global enable, in-service state and the request.
- R12: `ret_stb` clears the high in-service bit if it is set, and otherwise the low one.
- R13: A hardware event in the same cycle as a software clear or an auto-clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | NSRC | Per-source event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SW | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel` |
| ib_stb | input | 1 | Instruction boundary strobe |
| ib_short | input | 1 | Next instruction is single-cycle (with `ib_stb`) |
| vec_ack | input | 1 | Core has vectored to the request |
| ret_stb | input | 1 | Return from interrupt completed |
| irq_req | output | 1 | Vector request |
| irq_idx | output | IW | Winning source index |
| irq_vec | output | 16 | Vector address |
| irq_hi | output | 1 | Request is high priority |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |

## Verification
The bench walks every source through the full cycle of posting, global gating, vectoring, auto-clear and return. Each step catches a specific fault:
- A wrong vector formula or a bad bit-to-byte mapping would show up as a wrong index or address.
- A missing auto-clear, or an auto-clear applied to every source, would leave flags wrong after `vec_ack`.
- A return that arbitrated on its own boundary would re-request one instruction too early.

It also sweeps the lowest pending index across all seventeen positions, to expose an arbiter that favours high indices. A nesting sequence catches a level tracker that pops the wrong bit or lets a low request nest. The disable-latency cases separate a design that ignores the grace window from one that keeps it too long.

// File: rtl/irq_vectorer.sv
module irq_vectorer #(
  parameter int NSRC = 17,
  parameter logic [NSRC-1:0] AUTOCLR = NSRC'(17'h00011),
  parameter logic [15:0] VBASE = 16'h0003,
  parameter int VSTEP = 8,
  localparam int NB = (NSRC + 7) / 8,
  localparam int PW = NB * 8,
  localparam int IW = $clog2(NSRC),
  localparam int SW = $clog2(3 * NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_evt,
  input  logic            reg_we,
  input  logic [SW-1:0]   reg_sel,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            ib_stb,
  input  logic            ib_short,
  input  logic            vec_ack,
  input  logic            ret_stb,
  output logic            irq_req,
  output logic [IW-1:0]   irq_idx,
  output logic [15:0]     irq_vec,
  output logic            irq_hi,
  output logic            svc_hi,
  output logic            svc_lo
);

  logic [NSRC-1:0] flag_q, flag_n, en_q, en_n, pri_q, pri_n, grace_q, grace_n;
  logic            ge_q, ge_n, ge_grace;
  logic [NSRC-1:0] en_eff, elig, hi_m, lo_m;
  logic            hi_any, lo_any, take, win_hi, arb;
  logic [IW-1:0]   hi_w, lo_w, win;
  logic [PW-1:0]   fl_v, en_v, pr_v;
  int              sel_i;

  assign sel_i = int'(reg_sel);
  assign irq_vec = VBASE + 16'(int'(irq_idx) * VSTEP);

  always_comb begin
    flag_n = flag_q;
    en_n   = en_q;
    pri_n  = pri_q;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_we && sel_i == i / 8)          flag_n[i] = reg_wdata[i % 8];
      if (reg_we && sel_i == NB + i / 8)     en_n[i]   = reg_wdata[i % 8];
      if (reg_we && sel_i == 2 * NB + i / 8) pri_n[i]  = reg_wdata[i % 8];
      if (vec_ack && irq_req && AUTOCLR[i] && int'(irq_idx) == i) flag_n[i] = 1'b0;
    end
    flag_n = flag_n | src_evt;
    ge_n = (reg_we && sel_i == 3 * NB) ? reg_wdata[7] : ge_q;
  end

  assign grace_n = (ib_stb ? '0 : grace_q) | (en_q & ~en_n);

  assign en_eff = en_q | (grace_q & {NSRC{ib_short}});
  assign elig   = flag_q & en_eff & {NSRC{ge_q | (ge_grace & ib_short)}};
  assign hi_m   = elig & pri_q;
  assign lo_m   = elig & ~pri_q;

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_w   = '0;
    lo_w   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_m[i]) begin hi_any = 1'b1; hi_w = IW'(i); end
      if (lo_m[i]) begin lo_any = 1'b1; lo_w = IW'(i); end
    end
  end

  assign arb    = ib_stb && !irq_req && !ret_stb;
  assign win_hi = hi_any && !svc_hi;
  assign take   = arb && (win_hi || (lo_any && !svc_hi && !svc_lo));
  assign win    = win_hi ? hi_w : lo_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= '0;
      en_q     <= '0;
      pri_q    <= '0;
      grace_q  <= '0;
      ge_q     <= 1'b0;
      ge_grace <= 1'b0;
      irq_req  <= 1'b0;
      irq_idx  <= '0;
      irq_hi   <= 1'b0;
      svc_hi   <= 1'b0;
      svc_lo   <= 1'b0;
    end else begin
      flag_q   <= flag_n;
      en_q     <= en_n;
      pri_q    <= pri_n;
      grace_q  <= grace_n;
      ge_q     <= ge_n;
      ge_grace <= (ib_stb ? 1'b0 : ge_grace) | (ge_q & ~ge_n);
      if (vec_ack && irq_req) begin
        irq_req <= 1'b0;
      end else if (take) begin
        irq_req <= 1'b1;
        irq_idx <= win;
        irq_hi  <= win_hi;
      end
      if (ret_stb) begin
        if (svc_hi) svc_hi <= 1'b0;
        else        svc_lo <= 1'b0;
      end
      if (vec_ack && irq_req) begin
        if (irq_hi) svc_hi <= 1'b1;
        else        svc_lo <= 1'b1;
      end
    end
  end

  assign fl_v = PW'(flag_q | src_evt);
  assign en_v = PW'(en_q);
  assign pr_v = PW'(pri_q);

  always_comb begin
    reg_rdata = 8'h00;
    if (sel_i < NB)              reg_rdata = fl_v[sel_i * 8 +: 8];
    else if (sel_i < 2 * NB)     reg_rdata = en_v[(sel_i - NB) * 8 +: 8];
    else if (sel_i < 3 * NB)     reg_rdata = pr_v[(sel_i - 2 * NB) * 8 +: 8];
    else if (sel_i == 3 * NB)    reg_rdata = {ge_q, 7'b0};
  end

endmodule

module irq_vectorer_chk #(
  parameter int NSRC = 17,
  parameter int IW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_evt,
  input logic            ib_stb,
  input logic            ib_short,
  input logic            vec_ack,
  input logic            ret_stb,
  input logic            irq_req,
  input logic [IW-1:0]   irq_idx,
  input logic            irq_hi,
  input logic            svc_hi,
  input logic            svc_lo,
  input logic [NSRC-1:0] flag_q,
  input logic            ge_q,
  input logic            ge_grace
);

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (src_evt != '0) |=> ((flag_q & $past(src_evt)) == $past(src_evt))); // R2

  AST_REQ_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> 1'($past(flag_q) >> irq_idx)); // R2

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> ($past(ge_q) || ($past(ge_grace) && $past(ib_short)))); // R3

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(ib_stb)); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !vec_ack) |=> (irq_req && $stable(irq_idx) && $stable(irq_hi))); // R4

  AST_RET_SLOT: assert property (@(posedge clk) disable iff (rst)
    (ret_stb && !irq_req) |=> !irq_req); // R7

  AST_HI_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(svc_hi)); // R9

  AST_LO_NO_NEST: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_req) && !irq_hi) |-> !$past(svc_lo)); // R9

endmodule

bind irq_vectorer irq_vectorer_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .src_evt(src_evt), .ib_stb(ib_stb), .ib_short(ib_short),
  .vec_ack(vec_ack), .ret_stb(ret_stb), .irq_req(irq_req), .irq_idx(irq_idx),
  .irq_hi(irq_hi), .svc_hi(svc_hi), .svc_lo(svc_lo), .flag_q(flag_q),
  .ge_q(ge_q), .ge_grace(ge_grace)
);

// File: tb/sim_irq_vectorer.sv
module sim_irq_vectorer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] evt = '0;
  logic        we = 1'b0;
  logic [3:0]  sel = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  rd;
  logic        ib = 1'b0, sh = 1'b0, ack = 1'b0, ret = 1'b0;
  logic        req, hi, shi, slo;
  logic [4:0]  idx;
  logic [15:0] vec;
  int tests = 0, fails = 0;
  localparam logic [16:0] AC = 17'h00011;

  always #5 clk = ~clk;

  irq_vectorer u0 (
    .clk(clk), .rst(rst), .src_evt(evt), .reg_we(we), .reg_sel(sel),
    .reg_wdata(wd), .reg_rdata(rd), .ib_stb(ib), .ib_short(sh),
    .vec_ack(ack), .ret_stb(ret), .irq_req(req), .irq_idx(idx),
    .irq_vec(vec), .irq_hi(hi), .svc_hi(shi), .svc_lo(slo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_rst();
    rst = 1'b1; @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input int s, input int d);
    we = 1'b1; sel = 4'(s); wd = 8'(d); @(negedge clk); we = 1'b0;
  endtask

  task automatic rdb(input int s, output int v);
    sel = 4'(s); #1; v = int'(rd);
  endtask

  task automatic bnd(input logic s);
    ib = 1'b1; sh = s; @(negedge clk); ib = 1'b0; sh = 1'b0;
  endtask

  task automatic pulse(input int i);
    evt = 17'(1) << i; @(negedge clk); evt = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; ib = 1'b1; @(negedge clk); ret = 1'b0; ib = 1'b0;
  endtask

  task automatic set_flags(input logic [16:0] m);
    wr(0, m[7:0]); wr(1, m[15:8]); wr(2, {7'b0, m[16]});
  endtask

  initial begin
    int v;
    @(negedge clk);
    do_rst();
    chk("R11 req after reset", req, 0);
    chk("R11 svc after reset", {shi, slo}, 0);
    for (int s = 0; s < 10; s++) begin
      rdb(s, v); chk("R11 register clear", v, 0);
    end

    for (int s = 0; s < 10; s++) begin
      int m;
      m = (s == 2 || s == 5 || s == 8) ? 8'h01 : (s == 9 ? 8'h80 : 8'hFF);
      wr(s, 8'hA5 ^ s);
      rdb(s, v); chk("R1 readback", v, (8'hA5 ^ s) & m);
    end

    for (int i = 0; i < 17; i++) begin
      int p;
      p = i % 2;
      do_rst();
      wr(3 + i / 8, 1 << (i % 8));
      if (p == 1) wr(6 + i / 8, 1 << (i % 8));
      pulse(i);
      rdb(i / 8, v); chk("R2 flag set", (v >> (i % 8)) & 1, 1);
      bnd(0);
      chk("R3 global off blocks", req, 0);
      wr(9, 8'h80);
      bnd(0);
      chk("R4 request", req, 1);
      chk("R4 index", idx, i);
      chk("R4 vector", vec, 3 + 8 * i);
      chk("R10 level", hi, p);
      bnd(0);
      chk("R4 held", idx, i);
      do_ack();
      chk("R4 drop on ack", req, 0);
      chk("R9 level in service", p ? shi : slo, 1);
      rdb(i / 8, v); chk("R6 auto-clear", (v >> (i % 8)) & 1, AC[i] ? 0 : 1);
      do_ret();
      chk("R7 no request at return", req, 0);
      chk("R12 level popped", {shi, slo}, 0);
      bnd(0);
      chk("R7 re-request after one", req, AC[i] ? 0 : 1);
    end

    do_rst();
    wr(9, 8'h80); pulse(9); bnd(0);
    chk("R2 disabled ignored", req, 0);
    rdb(1, v); chk("R2 disabled flag kept", v, 2);

    do_rst();
    wr(3, 8'h40); wr(9, 8'h80); wr(0, 8'h40);
    bnd(0);
    chk("R5 software set", req, 1);
    chk("R5 index", idx, 6);
    do_ack(); do_ret();
    wr(0, 0);
    rdb(0, v); chk("R5 software clear", v, 0);

    evt = 17'h40; we = 1'b1; sel = 0; wd = 0;
    @(negedge clk); evt = '0; we = 1'b0;
    rdb(0, v); chk("R13 event beats clear", v, 8'h40);
    evt = 17'h8; rdb(0, v); chk("R1 same-cycle read", v, 8'h48);
    @(negedge clk); evt = '0;

    for (int i = 0; i < 17; i++) begin
      do_rst();
      wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 1); wr(9, 8'h80);
      set_flags(17'h1FFFF & ~((17'(1) << i) - 17'(1)));
      bnd(0);
      chk("R10 lowest index wins", idx, i);
    end
    do_rst();
    wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 1); wr(8, 1); wr(9, 8'h80);
    set_flags(17'h10001);
    bnd(0);
    chk("R10 high beats low", idx, 16);

    do_rst();
    wr(3, 8'hFF); wr(6, 8'h82); wr(9, 8'h80);
    wr(0, 8'h08); bnd(0);
    chk("R9 low taken", idx, 3);
    do_ack();
    wr(0, 8'h28); bnd(0);
    chk("R9 low waits on low", req, 0);
    wr(0, 8'hA8); bnd(0);
    chk("R9 high preempts low", idx, 7);
    do_ack();
    chk("R9 both levels", {shi, slo}, 3);
    wr(0, 8'hAA); bnd(0);
    chk("R9 nothing under high", req, 0);
    do_ret();
    chk("R12 high popped first", {shi, slo}, 1);
    bnd(0);
    chk("R9 high after return", idx, 1);

    do_rst();
    wr(3, 4); wr(9, 8'h80); pulse(2); wr(3, 0);
    bnd(1);
    chk("R8 short follower taken", req, 1);
    do_rst();
    wr(3, 4); wr(9, 8'h80); pulse(2); wr(3, 0);
    bnd(0);
    chk("R8 long follower blocked", req, 0);
    bnd(1);
    chk("R8 grace expired", req, 0);
    do_rst();
    wr(3, 4); wr(9, 8'h80); pulse(2); wr(9, 0);
    bnd(1);
    chk("R8 global clear grace", req, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule